// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

A 32-bit down-counting timer sits behind a small word-addressed register bus. Software programs a start value, a prescale divider and two mode bits. Then it sets the enable bit. The counter steps down by one every (P+1) clock cycles. When a step takes it from one to zero, a sticky event flag is raised. Depending on the auto-reload bit, the counter then either restarts from the stored start value or parks at zero and stays idle.

A level interrupt output presents the event flag gated by an interrupt-enable bit. Software acknowledges an event by writing a one to the flag's bit in the status word. Reads are combinational from the address, and writes take effect on the clock edge on which `wr_en` is sampled high.

Top module: `ptmr_top`

## Requirements
- R1: After synchronous reset the load, counter, control and status words all read 0 and `irq` is 0.
- R2: Word decode uses `addr[4:2]`: 0 selects the load word, 1 the counter, 2 control and 3 status. Words 4 to 7 read 0, and writes to them change nothing. Control keeps bit 0 (enable), bit 1 (auto-reload), bit 2 (interrupt enable) and bits 15:8 (prescaler P). All other control bits read 0.
- R3: While enabled with a nonzero count, the counter decrements once every P+1 cycles. The first decrement lands P+1 cycles after the write that started or restarted counting.
- R4: A load-word write stores the value both in the load word and in the counter, and resets the prescaler phase.
- R5: A counter-word write changes the counter and resets the prescaler phase, but leaves the load word unchanged.
- R6: With auto-reload clear, the step from 1 to 0 sets the status flag. The counter then holds 0 and no further steps or events occur.
- R7: With auto-reload set, the step from 1 to 0 sets the status flag, reloads the counter from the load word, and counting continues.
- R8: `irq` equals status bit 0 ANDed with control bit 2. It follows either of them from the same clock edge.
- R9: A status write clears bit 0 when data bit 0 is 1, and leaves the flag unchanged when it is 0.
- R10: A control write with enable set is ignored for the count and phase when the timer is already enabled with a nonzero count. Otherwise it starts counting, and if auto-reload is set in the written value, the counter is first loaded from the load word.
- R11: The counter word reads 0 whenever the enable bit is 0, but the stored count is kept.
- R12: If a status clear and an expiry fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address in the 32-byte register window |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt: event flag AND interrupt enable |

## Verification
Two functions can land on the same edge: software acknowledging the event flag, and the counter expiring and setting that flag again. The bench starts a one-shot count of three with no prescale. It times a status write of one so that the write strobe is sampled on exactly the edge where the counter steps from one to zero. The flag must read 1 afterwards. A second, related collision is a re-enable write that arrives in the middle of a prescale period. This is judged by checking that the count is unchanged and that the next decrement still arrives at the original phase.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int PRESC_W   = 8;
    localparam int PRESC_LSB = 8;
    localparam int WSEL_W    = ADDR_W - 2;

    localparam logic [WSEL_W-1:0] W_LOAD  = 3'd0;
    localparam logic [WSEL_W-1:0] W_COUNT = 3'd1;
    localparam logic [WSEL_W-1:0] W_CTRL  = 3'd2;
    localparam logic [WSEL_W-1:0] W_STAT  = 3'd3;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               irq_en;
        logic               reload;
        logic               enable;
    } ctrl_t;

    typedef struct packed {
        logic load;
        logic count;
        logic ctrl;
        logic stat;
    } wr_dec_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.enable = w[0];
        c.reload = w[1];
        c.irq_en = w[2];
        c.presc  = w[PRESC_LSB +: PRESC_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.enable;
        w[1] = c.reload;
        w[2] = c.irq_en;
        w[PRESC_LSB +: PRESC_W] = c.presc;
        return w;
    endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int W = ptmr_pkg::PRESC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] phase_q;

    // >= keeps the divider safe if P is lowered mid-period
    assign tick = run && !restart && (phase_q >= div);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R3: with a nonzero divider, two ticks never come back to back
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));

    // R3: a restart always clears the phase
    assert_restart_phase_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == '0));

endmodule

// File: rtl/ptmr_down_counter.sv
module ptmr_down_counter #(
    parameter int W = ptmr_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_val,
    input  logic [W-1:0] wr_data,
    input  logic         start_reload,
    input  logic         auto_reload,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] count_q;

    assign count  = count_q;
    assign expire = tick && (count_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (wr_val) begin
            count_q <= wr_data;
        end else if (start_reload) begin
            count_q <= load_val;
        end else if (expire) begin
            count_q <= auto_reload ? load_val : '0;
        end else if (tick) begin
            count_q <= count_q - ONE;
        end
    end

    // R6: an idle (zero) counter receives no ticks
    assert_idle_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0) |-> !tick);

    // R6: one-shot expiry parks the counter at zero
    assert_oneshot_park_R6: assert property (@(posedge clk) disable iff (rst)
        (expire && !auto_reload && !wr_val && !start_reload) |=> (count_q == '0));

    // R7: auto-reload expiry copies the load word
    assert_reload_value_R7: assert property (@(posedge clk) disable iff (rst)
        (expire && auto_reload && !wr_val && !start_reload)
        |=> (count_q == $past(load_val)));

    // R3: an ordinary tick steps down by exactly one
    assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q > ONE && !wr_val && !start_reload)
        |=> (count_q == $past(count_q) - ONE));

endmodule

// File: rtl/ptmr_event_flag.sv
module ptmr_event_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr_wr,
    input  logic clr_bit,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    assign flag = flag_q;
    assign irq  = flag_q && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr_wr && clr_bit) begin
            flag_q <= 1'b0;
        end
    end

    // R12: an expiry always leaves the flag set, even against a clear
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        set |=> flag_q);

    // R9: a write of one clears the flag when nothing sets it
    assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_bit && !set) |=> !flag_q);

    // R9: without a set or a one-write, the flag holds
    assert_w1c_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!set && !(clr_wr && clr_bit)) |=> (flag_q == $past(flag_q)));

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    localparam int SW = AW - 2;

    logic [SW-1:0] wsel;
    logic          unused_byte_lanes;
    wr_dec_t       wr;
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_new;
    logic [DW-1:0] load_q;
    logic [DW-1:0] count;
    logic          running;
    logic          start;
    logic          start_reload;
    logic          wr_val;
    logic          restart;
    logic          tick;
    logic          expire;
    logic          flag;

    assign wsel              = addr[AW-1:2];
    assign unused_byte_lanes = ^addr[1:0];

    assign wr.load  = wr_en && (wsel == W_LOAD);
    assign wr.count = wr_en && (wsel == W_COUNT);
    assign wr.ctrl  = wr_en && (wsel == W_CTRL);
    assign wr.stat  = wr_en && (wsel == W_STAT);

    assign ctrl_new = ctrl_unpack(wr_data);
    assign running  = ctrl_q.enable && (count != '0);

    // start only when not already running
    assign start        = wr.ctrl && ctrl_new.enable && !running;
    assign start_reload = start && ctrl_new.reload;
    assign wr_val       = wr.load || wr.count;
    assign restart      = wr_val || start;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr.load) begin
                load_q <= wr_data;
            end
            if (wr.ctrl) begin
                ctrl_q <= ctrl_new;
            end
        end
    end

    ptmr_prescaler #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (restart),
        .div     (ctrl_q.presc),
        .tick    (tick)
    );

    ptmr_down_counter #(.W(DW)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .wr_val       (wr_val),
        .wr_data      (wr_data),
        .start_reload (start_reload),
        .auto_reload  (ctrl_q.reload),
        .load_val     (load_q),
        .count        (count),
        .expire       (expire)
    );

    ptmr_event_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set     (expire),
        .clr_wr  (wr.stat),
        .clr_bit (wr_data[0]),
        .irq_en  (ctrl_q.irq_en),
        .flag    (flag),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        case (wsel)
            W_LOAD:  rd_data = load_q;
            W_COUNT: rd_data = ctrl_q.enable ? count : '0;
            W_CTRL:  rd_data = ctrl_pack(ctrl_q);
            W_STAT:  rd_data = {{(DW-1){1'b0}}, flag};
            default: rd_data = '0;
        endcase
    end

    // R4: a load write lands in both the load word and the counter
    assert_load_both_R4: assert property (@(posedge clk) disable iff (rst)
        wr.load |=> (load_q == $past(wr_data) && count == $past(wr_data)));

    // R5: a counter write leaves the load word alone
    assert_count_only_R5: assert property (@(posedge clk) disable iff (rst)
        wr.count |=> (load_q == $past(load_q)));

    // R10: re-enabling a running timer only lets the normal step happen
    assert_rearm_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr.ctrl && wr_data[0] && ctrl_q.enable && count > 1)
        |=> (count == $past(count) || count == $past(count) - 1));

    // R2: words 4..7 never disturb the stored words
    assert_hole_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel[SW-1]) |=> (load_q == $past(load_q) && ctrl_q == $past(ctrl_q)));

endmodule

// File: tb/ptmr_top_test.sv
module ptmr_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int tests = 0;
    int fails = 0;

    localparam logic [4:0] A_LOAD = 5'h00;
    localparam logic [4:0] A_CNT  = 5'h04;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_STAT = 5'h0C;

    always #10 clk = ~clk;  // 50 MHz

    ptmr_top uut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 load", A_LOAD, 32'h0);
        rd_chk("R1 count", A_CNT, 32'h0);
        rd_chk("R1 ctrl", A_CTRL, 32'h0);
        rd_chk("R1 stat", A_STAT, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regmap;
        wr(A_LOAD, 32'h0000_1234);
        rd_chk("R2 load readback", A_LOAD, 32'h0000_1234);
        rd_chk("R11 count disabled", A_CNT, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd_chk("R2 ctrl mask", A_CTRL, 32'h0000_FF00);
        wr(5'h10, 32'hDEAD_BEEF);
        rd_chk("R2 hole 0x10", 5'h10, 32'h0);
        rd_chk("R2 hole 0x1C", 5'h1C, 32'h0);
        rd_chk("R2 load kept", A_LOAD, 32'h0000_1234);
        rd_chk("R2 ctrl kept", A_CTRL, 32'h0000_FF00);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_prescale;
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'h0000_0301);     // enable, P=3
        idle(3);
        rd_chk("R3 before first step", A_CNT, 32'd5);
        idle(1);
        rd_chk("R3 first step", A_CNT, 32'd4);
        idle(4);
        rd_chk("R3 second step", A_CNT, 32'd3);
    endtask

    task automatic t_writes;
        wr(A_LOAD, 32'd10);
        rd_chk("R4 count follows load", A_CNT, 32'd10);
        idle(3);
        rd_chk("R4 phase restarted", A_CNT, 32'd10);
        idle(1);
        rd_chk("R4 step after restart", A_CNT, 32'd9);
        wr(A_CNT, 32'd7);
        rd_chk("R5 count written", A_CNT, 32'd7);
        rd_chk("R5 load untouched", A_LOAD, 32'd10);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_oneshot;
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'h0000_0005);     // enable, irq enable, P=0, one-shot
        idle(2);
        rd_chk("R6 count at 1", A_CNT, 32'd1);
        rd_chk("R6 no event yet", A_STAT, 32'd0);
        check("R8 irq low", {31'b0, irq}, 32'h0);
        idle(1);
        rd_chk("R6 event set", A_STAT, 32'd1);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        idle(5);
        rd_chk("R6 parked", A_CNT, 32'd0);
        rd_chk("R6 flag sticky", A_STAT, 32'd1);
        wr(A_CTRL, 32'h0000_0001);     // irq enable off
        check("R8 irq gated off", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h0000_0005);
        check("R8 irq gated on", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'hFFFF_FFFE);
        rd_chk("R9 zero write keeps flag", A_STAT, 32'd1);
        wr(A_STAT, 32'h1);
        rd_chk("R9 one write clears", A_STAT, 32'd0);
        check("R8 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_autoreload;
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'h0000_0007);     // enable, reload, irq, P=0
        idle(2);
        rd_chk("R7 reloaded", A_CNT, 32'd2);
        rd_chk("R7 event set", A_STAT, 32'd1);
        idle(1);
        rd_chk("R7 keeps counting", A_CNT, 32'd1);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h1);
    endtask

    task automatic t_rearm;
        wr(A_LOAD, 32'd100);
        wr(A_CNT, 32'd7);
        wr(A_CTRL, 32'h0000_FF03);     // enable, reload, P=255
        rd_chk("R10 start loads from load", A_CNT, 32'd100);
        wr(A_CNT, 32'd40);
        idle(4);
        wr(A_CTRL, 32'h0000_FF03);
        rd_chk("R10 rearm ignored", A_CNT, 32'd40);
        idle(250);
        rd_chk("R10 phase undisturbed a", A_CNT, 32'd40);
        idle(1);
        rd_chk("R10 phase undisturbed b", A_CNT, 32'd39);
        wr(A_CTRL, 32'h0);
        rd_chk("R11 reads zero disabled", A_CNT, 32'd0);
        wr(A_CTRL, 32'h0000_0001);
        rd_chk("R11 count retained", A_CNT, 32'd39);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_collision;
        wr(A_STAT, 32'h1);
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'h0000_0005);
        idle(2);
        wr(A_STAT, 32'h1);             // sampled on the expiry edge
        rd_chk("R12 set beats clear", A_STAT, 32'd1);
        check("R12 irq", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_prescale();
        t_writes();
        t_oneshot();
        t_autoreload();
        t_rearm();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule